// File: doc/BRIEF.md
# Blocking Binary Lock with Hardware Wait Queue

This block is a one-bit mutual-exclusion lock shared by software threads on a processor and by threads built in logic. A thread asks for the lock by presenting its identifier on the request port. It then compares the owner outputs with its own identifier to learn whether it won. A thread that finds the lock taken does not spin. Its identifier goes into an internal first-in first-out wait queue, and the thread can be suspended by whatever runs it.

When the owner presents its own identifier on the release port, the lock becomes free. If threads are waiting, one wake-up is scheduled for each such release. A dispatcher takes the oldest waiting identifier and moves it into one of two ready queues. The top bit of the identifier chooses the queue: set for a hardware thread, clear for a software thread. Each ready queue shows a level notification while it holds entries, and its consumer removes entries with a pop strobe. A woken thread must present its request again, because a wake-up does not hand the lock over.

Lock control state machine: `LK_FREE` moves to `LK_OWNED` when a request arrives. `LK_OWNED` moves to `LK_FREE` on a release carrying the owner's identifier. Dispatcher state machine: `DS_IDLE` means no wake-up is pending. `DS_SEND` means a wake-up is pending and an identifier moves on every cycle its destination has room. `DS_STALL` means the destination ready queue was full in the last cycle.

Top module: `blocking_lock`

## Requirements
- R1: After reset the lock is free (`owner_valid` = 0), both ready notifications are low and `wq_overflow` is 0.
- R2: A request while the lock is free makes `owner_valid` = 1 and `owner_id` equal to the requesting identifier after the next clock edge. This holds for a woken thread that asks again.
- R3: A request while the lock is owned leaves the owner unchanged and appends the identifier to the tail of the wait queue.
- R4: A release whose identifier equals `owner_id` makes `owner_valid` = 0 after the next clock edge.
- R5: A release whose identifier differs from `owner_id`, or a release while the lock is free, leaves the owner outputs unchanged and dispatches nothing.
- R6: A release with a non-empty wait queue (entries queued in the same cycle count) moves exactly one identifier, the oldest one, into a ready queue. It is visible on the ready outputs after the second clock edge following the release, provided the destination has room.
- R7: An identifier whose top bit is 1 goes to the hardware ready queue (`hw_tid`/`hw_avail`). An identifier whose top bit is 0 goes to the processor ready queue (`cpu_tid`/`cpu_irq`).
- R8: `cpu_irq` and `hw_avail` are high exactly while their ready queue holds entries. A pop strobe removes the head, and entries leave in arrival order.
- R9: A request while the lock is owned and the wait queue is full is dropped, never dispatched, and sets `wq_overflow`. The flag stays 1 until reset.
- R10: A release with an empty wait queue dispatches nothing.
- R11: When the destination ready queue is full, the pending identifier stays at the head of the wait queue. It is delivered in the cycle after a pop frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lock request strobe |
| req_id | input | ID_W | Requesting thread identifier |
| rel_valid | input | 1 | Release strobe |
| rel_id | input | ID_W | Releasing thread identifier |
| owner_valid | output | 1 | Lock is held |
| owner_id | output | ID_W | Identifier of the holder |
| wq_overflow | output | 1 | Sticky: a request was dropped on a full wait queue |
| cpu_pop | input | 1 | Remove head of processor ready queue |
| cpu_tid | output | ID_W | Head of processor ready queue |
| cpu_irq | output | 1 | Processor ready queue not empty (level interrupt) |
| hw_pop | input | 1 | Remove head of hardware ready queue |
| hw_tid | output | ID_W | Head of hardware ready queue |
| hw_avail | output | 1 | Hardware ready queue not empty |

## Verification
The hardest situation to reach is a wake-up that stalls because the processor ready queue is full while identifiers are still waiting. Getting there needs a full wait queue and several release and re-acquire rounds with no consumer pops in between. The stimulus holds the lock with one identifier and queues four waiters, then sends a fifth to force the overflow drop. It then releases and re-takes the lock repeatedly without popping, so the third wake-up finds the ready queue full. Single pops afterwards show the stalled identifier arriving one cycle later, in order, and show that the dropped identifier never appears.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    typedef enum logic {
        LK_FREE,
        LK_OWNED
    } lock_state_e;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_SEND,
        DS_STALL
    } disp_state_e;

endpackage

// File: rtl/blk_lock_fifo.sv
module blk_lock_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign count   = cnt;
    assign dout    = store[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
    import blk_lock_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [ID_W-1:0] req_id,
    input  logic            rel_valid,
    input  logic [ID_W-1:0] rel_id,
    input  logic            wq_full,
    output logic            owner_valid,
    output logic [ID_W-1:0] owner_id,
    output logic            wq_push,
    output logic            release_ev,
    output logic            overflow
);

    lock_state_e     state_q;
    lock_state_e     state_d;
    logic [ID_W-1:0] owner_q;
    logic            ovf_q;
    logic            grant;
    logic            drop;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_FREE: begin
                if (req_valid) begin
                    state_d = LK_OWNED;
                end
            end
            LK_OWNED: begin
                if (rel_valid && (rel_id == owner_q)) begin
                    state_d = LK_FREE;
                end
            end
            default: state_d = LK_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from state and inputs
    always_comb begin
        grant      = 1'b0;
        wq_push    = 1'b0;
        drop       = 1'b0;
        release_ev = 1'b0;
        unique case (state_q)
            LK_FREE: begin
                grant = req_valid;
            end
            LK_OWNED: begin
                wq_push    = req_valid && !wq_full;
                drop       = req_valid && wq_full;
                release_ev = rel_valid && (rel_id == owner_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (grant) begin
                owner_q <= req_id;
            end
            if (drop) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign owner_valid = (state_q == LK_OWNED);
    assign owner_id    = owner_q;
    assign overflow    = ovf_q;

endmodule

// File: rtl/blk_lock_dispatch.sv
module blk_lock_dispatch
    import blk_lock_pkg::*;
#(
    parameter int ID_W     = 8,
    parameter int WQ_DEPTH = 4,
    localparam int CW      = $clog2(WQ_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wake,
    input  logic            wq_push,
    input  logic            wq_empty,
    input  logic [CW-1:0]   wq_count,
    input  logic [ID_W-1:0] wq_head,
    input  logic            cpu_full,
    input  logic            hw_full,
    output logic            wq_pop,
    output logic            cpu_push,
    output logic            hw_push
);

    disp_state_e   state_q;
    disp_state_e   state_d;
    logic [CW-1:0] credit_q;
    logic [CW:0]   credit_sum;
    logic [CW:0]   count_nx;
    logic [CW-1:0] credit_nx;
    logic          to_hw;
    logic          room;
    logic          go;

    assign to_hw = wq_head[ID_W-1];
    assign room  = to_hw ? !hw_full : !cpu_full;

    // outputs: move one identifier when a wake-up is pending
    always_comb begin
        go = 1'b0;
        unique case (state_q)
            DS_IDLE:  go = 1'b0;
            DS_SEND,
            DS_STALL: go = !wq_empty && room;
            default:  go = 1'b0;
        endcase
        wq_pop   = go;
        cpu_push = go && !to_hw;
        hw_push  = go && to_hw;
    end

    // pending wake-ups never exceed the waiters left in the queue
    always_comb begin
        credit_sum = {1'b0, credit_q} + (CW+1)'(wake) - (CW+1)'(go);
        count_nx   = {1'b0, wq_count} + (CW+1)'(wq_push) - (CW+1)'(go);
        credit_nx  = (credit_sum > count_nx) ? count_nx[CW-1:0] : credit_sum[CW-1:0];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_IDLE,
            DS_SEND,
            DS_STALL: begin
                if (credit_nx == '0) begin
                    state_d = DS_IDLE;
                end else if ((state_q != DS_IDLE) && !go) begin
                    state_d = DS_STALL;
                end else begin
                    state_d = DS_SEND;
                end
            end
            default: state_d = DS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= DS_IDLE;
            credit_q <= '0;
        end else begin
            state_q  <= state_d;
            credit_q <= credit_nx;
        end
    end

endmodule

// File: rtl/blocking_lock.sv
module blocking_lock #(
    parameter int ID_W     = 8,
    parameter int WQ_DEPTH = 4,
    parameter int RQ_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [ID_W-1:0] req_id,
    input  logic            rel_valid,
    input  logic [ID_W-1:0] rel_id,
    output logic            owner_valid,
    output logic [ID_W-1:0] owner_id,
    output logic            wq_overflow,
    input  logic            cpu_pop,
    output logic [ID_W-1:0] cpu_tid,
    output logic            cpu_irq,
    input  logic            hw_pop,
    output logic [ID_W-1:0] hw_tid,
    output logic            hw_avail
);

    localparam int WCW = $clog2(WQ_DEPTH + 1);
    localparam int RCW = $clog2(RQ_DEPTH + 1);

    logic            wq_push;
    logic            wq_pop;
    logic            wq_empty;
    logic            wq_full;
    logic [WCW-1:0]  wq_count;
    logic [ID_W-1:0] wq_head;
    logic            release_ev;
    logic            cpu_push;
    logic            hw_push;
    logic            cpu_empty;
    logic            cpu_full;
    logic            hw_empty;
    logic            hw_full;
    logic [RCW-1:0]  cpu_count;
    logic [RCW-1:0]  hw_count;

    blk_lock_ctrl #(.ID_W(ID_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_id      (req_id),
        .rel_valid   (rel_valid),
        .rel_id      (rel_id),
        .wq_full     (wq_full),
        .owner_valid (owner_valid),
        .owner_id    (owner_id),
        .wq_push     (wq_push),
        .release_ev  (release_ev),
        .overflow    (wq_overflow)
    );

    blk_lock_fifo #(.W(ID_W), .DEPTH(WQ_DEPTH)) waitq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wq_push),
        .din   (req_id),
        .pop   (wq_pop),
        .dout  (wq_head),
        .empty (wq_empty),
        .full  (wq_full),
        .count (wq_count)
    );

    blk_lock_dispatch #(.ID_W(ID_W), .WQ_DEPTH(WQ_DEPTH)) disp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake     (release_ev),
        .wq_push  (wq_push),
        .wq_empty (wq_empty),
        .wq_count (wq_count),
        .wq_head  (wq_head),
        .cpu_full (cpu_full),
        .hw_full  (hw_full),
        .wq_pop   (wq_pop),
        .cpu_push (cpu_push),
        .hw_push  (hw_push)
    );

    blk_lock_fifo #(.W(ID_W), .DEPTH(RQ_DEPTH)) cpuq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cpu_push),
        .din   (wq_head),
        .pop   (cpu_pop),
        .dout  (cpu_tid),
        .empty (cpu_empty),
        .full  (cpu_full),
        .count (cpu_count)
    );

    blk_lock_fifo #(.W(ID_W), .DEPTH(RQ_DEPTH)) hwq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (hw_push),
        .din   (wq_head),
        .pop   (hw_pop),
        .dout  (hw_tid),
        .empty (hw_empty),
        .full  (hw_full),
        .count (hw_count)
    );

    assign cpu_irq  = !cpu_empty;
    assign hw_avail = !hw_empty;

endmodule

// File: rtl/blocking_lock_chk.sv
module blocking_lock_chk #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [ID_W-1:0] req_id,
    input logic            rel_valid,
    input logic [ID_W-1:0] rel_id,
    input logic            owner_valid,
    input logic [ID_W-1:0] owner_id,
    input logic            wq_overflow,
    input logic [ID_W-1:0] cpu_tid,
    input logic            cpu_irq,
    input logic [ID_W-1:0] hw_tid,
    input logic            hw_avail
);

    // R2
    free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_valid && req_valid) |=> (owner_valid && owner_id == $past(req_id)));

    // R4
    owner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid && rel_valid && rel_id == owner_id) |=> !owner_valid);

    // R5
    foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid && rel_valid && rel_id != owner_id)
        |=> (owner_valid && owner_id == $past(owner_id)));

    // R9
    sticky_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wq_overflow |=> wq_overflow);

    // R7
    hw_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_avail |-> hw_tid[ID_W-1]);

    // R7
    cpu_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> !cpu_tid[ID_W-1]);

endmodule

bind blocking_lock blocking_lock_chk #(.ID_W(ID_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_id      (req_id),
    .rel_valid   (rel_valid),
    .rel_id      (rel_id),
    .owner_valid (owner_valid),
    .owner_id    (owner_id),
    .wq_overflow (wq_overflow),
    .cpu_tid     (cpu_tid),
    .cpu_irq     (cpu_irq),
    .hw_tid      (hw_tid),
    .hw_avail    (hw_avail)
);

// File: tb/blocking_lock_tb_top.sv
module blocking_lock_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ID_W       = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic            rel_valid = 1'b0;
    logic [ID_W-1:0] rel_id = '0;
    logic            owner_valid;
    logic [ID_W-1:0] owner_id;
    logic            wq_overflow;
    logic            cpu_pop = 1'b0;
    logic [ID_W-1:0] cpu_tid;
    logic            cpu_irq;
    logic            hw_pop = 1'b0;
    logic [ID_W-1:0] hw_tid;
    logic            hw_avail;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    blocking_lock #(.ID_W(ID_W), .WQ_DEPTH(4), .RQ_DEPTH(2)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_id      (req_id),
        .rel_valid   (rel_valid),
        .rel_id      (rel_id),
        .owner_valid (owner_valid),
        .owner_id    (owner_id),
        .wq_overflow (wq_overflow),
        .cpu_pop     (cpu_pop),
        .cpu_tid     (cpu_tid),
        .cpu_irq     (cpu_irq),
        .hw_pop      (hw_pop),
        .hw_tid      (hw_tid),
        .hw_avail    (hw_avail)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [ID_W-1:0] id);
        @(negedge clk);
        req_valid = 1'b1;
        req_id    = id;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_rel(input logic [ID_W-1:0] id);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_id    = id;
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic do_cpu_pop();
        @(negedge clk);
        cpu_pop = 1'b1;
        @(negedge clk);
        cpu_pop = 1'b0;
    endtask

    task automatic do_hw_pop();
        @(negedge clk);
        hw_pop = 1'b1;
        @(negedge clk);
        hw_pop = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reset_test();
        check("R1 owner_valid", owner_valid, 0);
        check("R1 cpu_irq", cpu_irq, 0);
        check("R1 hw_avail", hw_avail, 0);
        check("R1 wq_overflow", wq_overflow, 0);
    endtask

    task automatic queue_dispatch_test();
        do_req(8'h05);
        check("R2 owner_valid", owner_valid, 1);
        check("R2 owner_id", owner_id, 8'h05);
        do_req(8'h11);
        do_req(8'h82);
        do_req(8'h13);
        check("R3 owner kept", owner_id, 8'h05);
        do_rel(8'h09);
        idle(1);
        check("R5 owner_valid after foreign release", owner_valid, 1);
        check("R5 owner_id after foreign release", owner_id, 8'h05);
        check("R5 no dispatch", cpu_irq | hw_avail, 0);
        do_rel(8'h05);
        check("R4 freed", owner_valid, 0);
        idle(1);
        check("R6 cpu_irq", cpu_irq, 1);
        check("R6 oldest waiter", cpu_tid, 8'h11);
        check("R6 one per release", hw_avail, 0);
        do_req(8'h11);
        check("R2 woken regrant", owner_id, 8'h11);
        do_rel(8'h11);
        idle(1);
        check("R7 hw_avail", hw_avail, 1);
        check("R7 hw_tid", hw_tid, 8'h82);
        do_req(8'h82);
        do_rel(8'h82);
        idle(1);
        check("R8 head kept", cpu_tid, 8'h11);
        do_cpu_pop();
        check("R8 order", cpu_tid, 8'h13);
        check("R8 irq still high", cpu_irq, 1);
        do_cpu_pop();
        check("R8 irq low when empty", cpu_irq, 0);
        do_hw_pop();
        check("R8 hw_avail low", hw_avail, 0);
        do_req(8'h30);
        do_rel(8'h30);
        idle(2);
        check("R10 no cpu dispatch", cpu_irq, 0);
        check("R10 no hw dispatch", hw_avail, 0);
        do_rel(8'h30);
        check("R5 release while free", owner_valid, 0);
    endtask

    task automatic overflow_stall_test();
        do_req(8'h01);
        do_req(8'h21);
        do_req(8'h22);
        do_req(8'h23);
        do_req(8'h24);
        check("R9 no overflow yet", wq_overflow, 0);
        do_req(8'h25);
        check("R9 overflow set", wq_overflow, 1);
        do_rel(8'h01);
        idle(1);
        check("R6 first waiter", cpu_tid, 8'h21);
        do_req(8'h01);
        do_rel(8'h01);
        do_req(8'h01);
        do_rel(8'h01);
        idle(2);
        check("R11 stalled head", cpu_tid, 8'h21);
        do_cpu_pop();
        check("R11 next head", cpu_tid, 8'h22);
        idle(1);
        do_cpu_pop();
        check("R11 stalled id delivered", cpu_tid, 8'h23);
        do_cpu_pop();
        check("R11 queue drained", cpu_irq, 0);
        do_req(8'h01);
        do_rel(8'h01);
        idle(1);
        check("R3 fourth waiter", cpu_tid, 8'h24);
        do_cpu_pop();
        do_req(8'h01);
        do_rel(8'h01);
        idle(2);
        check("R9 dropped id absent", cpu_irq, 0);
        check("R9 overflow sticky", wq_overflow, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_test();
        queue_dispatch_test();
        overflow_stall_test();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule